// File: doc/BRIEF.md
# Synchronous Line Receiver with Sync Hunt

This block receives one synchronous serial line. The modem supplies a receive clock with the data, and the block samples the data line on each rising edge of that clock. Before it can frame characters it scans the bit stream for a sync character set by software. It looks at a sliding window on every bit. It can be told to accept a single sync character or to require two sync characters back to back. Once in sync it builds characters of 6, 8 or 12 bits into a 12-bit receive buffer.

Each complete character sets a done flag. A character that completes while the previous one is still unread sets an overrun flag. If carrier detect drops while the receiver is enabled, a carrier-lost flag is set. An interrupt request summarises done and carrier-lost. Software reads the buffer with a one-cycle read strobe, and that strobe clears the flags. Dropping the enable sends the receiver back to the hunt.

The receive clock, the serial data and carrier detect come in through two-flop synchronisers in the system clock domain. Each bit is taken on the rising edge of the synchronised receive clock.

Top module: `sync_line_rx`

## Requirements
- R1: The length select chooses the character length: 00 gives 6 bits, 01 gives 8 bits, and 10 or 11 gives 12 bits.
- R2: Bits are taken on rising edges of `rx_clk` and arrive least significant bit first. A character appears right-justified in `rd_data[11:0]`, and `rd_data[15:12]` always reads zero.
- R3: While hunting, the receiver compares the last L received bits with `sync_pat[L-1:0]` after every bit. Bits of `sync_pat` above L are ignored. With `two_sync` low, one match declares sync (`in_sync` goes high), and the next L bits form the first character.
- R4: With `two_sync` high, the L bits that directly follow a first match must also equal the sync pattern before sync is declared. If they do not, the receiver goes back to hunting, no character is delivered and `in_sync` stays low.
- R5: The sync characters that establish sync are not delivered. After sync, every group of L bits is delivered as a character.
- R6: A completed character sets `done` and loads the buffer. A one-cycle `rd_ack` clears `done`. `irq` follows `done` OR `carrier_lost`, one cycle later.
- R7: If a character completes while `done` is set and `rd_ack` is low, `overrun` is set and the buffer takes the newer character. `rd_ack` clears `overrun`.
- R8: A falling edge on `carrier` while `rx_en` is high sets `carrier_lost`. A falling edge while `rx_en` is low does not. `rd_ack` clears `carrier_lost`.
- R9: While `rx_en` is low, no character is delivered and `in_sync` is low. After `rx_en` rises again, the receiver must find sync again before it frames any character.
- R10: After reset, `rd_data`, `done`, `overrun`, `carrier_lost`, `in_sync` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_clk | input | 1 | Receive bit clock from the modem; data is taken on its rising edge |
| rx_data | input | 1 | Serial receive data |
| carrier | input | 1 | Carrier detect level |
| rx_en | input | 1 | Receiver enable |
| len_sel | input | 2 | Character length select |
| sync_pat | input | 12 | Sync character, right-justified |
| two_sync | input | 1 | Require two consecutive sync characters |
| rd_ack | input | 1 | Read strobe; clears the status flags |
| rd_data | output | 16 | Received character, upper four bits zero |
| done | output | 1 | Character waiting |
| overrun | output | 1 | Character overwritten before it was read |
| carrier_lost | output | 1 | Carrier dropped while enabled |
| in_sync | output | 1 | Receiver is framing characters |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `len_sel`, `sync_pat` and `two_sync` stay constant while `rx_en` is high. The bench changes them only with the receiver disabled. The assertions also assume that each phase of `rx_clk` lasts several system clocks, so that every bit produces exactly one sampling strobe; the bench holds each phase for four cycles. Before any sync character, the stimulus sends idle zeros, and every sync pattern has its least significant bit set. As a result, no window that straddles the idle bits and the start of a sync can match early, and the framing the bench expects is exact.

// File: rtl/sync_line_rx_pkg.sv
package sync_line_rx_pkg;
  parameter int DATA_W = 12;
  parameter int WORD_W = 16;
  parameter int CNT_W  = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {ST_HUNT, ST_SYNC1, ST_FRAME} hunt_st_t;

  function automatic logic [CNT_W-1:0] char_len(input logic [1:0] sel);
    case (sel)
      2'b00:   char_len = CNT_W'(6);
      2'b01:   char_len = CNT_W'(8);
      default: char_len = CNT_W'(DATA_W);
    endcase
  endfunction
endpackage

// File: rtl/slr_input_sync.sv
module slr_input_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_clk,
  input  logic rx_data,
  input  logic carrier,
  output logic bit_tick,
  output logic bit_val,
  output logic carrier_s
);
  logic [STAGES:0]   clk_sh;
  logic [STAGES-1:0] dat_sh;
  logic [STAGES-1:0] car_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sh <= '0;
      dat_sh <= '0;
      car_sh <= '0;
    end else begin
      clk_sh <= {clk_sh[STAGES-1:0], rx_clk};
      dat_sh <= {dat_sh[STAGES-2:0], rx_data};
      car_sh <= {car_sh[STAGES-2:0], carrier};
    end
  end

  assign bit_tick  = clk_sh[STAGES-1] & ~clk_sh[STAGES];
  assign bit_val   = dat_sh[STAGES-1];
  assign carrier_s = car_sh[STAGES-1];
endmodule

// File: rtl/slr_framer.sv
module slr_framer
  import sync_line_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              bit_tick,
  input  logic              bit_val,
  input  logic [1:0]        len_sel,
  input  logic [DATA_W-1:0] sync_pat,
  input  logic              two_sync,
  output logic              char_done,
  output logic [DATA_W-1:0] char_val,
  output logic              in_sync
);
  hunt_st_t          state;
  logic [DATA_W-1:0] sr, sr_nx, win_nx, mask;
  logic [CNT_W-1:0]  cnt, len;
  logic              match, last, step;

  assign len    = char_len(len_sel);
  assign sr_nx  = {bit_val, sr[DATA_W-1:1]};
  assign win_nx = sr_nx >> (DATA_W - int'(len));
  assign mask   = {DATA_W{1'b1}} >> (DATA_W - int'(len));
  assign match  = (win_nx == (sync_pat & mask));
  assign last   = (cnt == len - 1'b1);
  assign step   = en & bit_tick;

  assign char_done = step & (state == ST_FRAME) & last;
  assign char_val  = win_nx;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state   <= ST_HUNT;
      cnt     <= '0;
      sr      <= '0;
      in_sync <= 1'b0;
    end else if (step) begin
      sr <= sr_nx;
      case (state)
        ST_HUNT: begin
          cnt <= '0;
          if (match) begin
            state   <= two_sync ? ST_SYNC1 : ST_FRAME;
            in_sync <= ~two_sync;
          end
        end
        ST_SYNC1: begin
          if (last) begin
            cnt     <= '0;
            state   <= match ? ST_FRAME : ST_HUNT;
            in_sync <= match;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: cnt <= last ? '0 : cnt + 1'b1;
      endcase
    end
  end

  // R9
  hunt_on_disable_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (state == ST_HUNT) && !in_sync && !char_done);
  // R4
  second_sync_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SYNC1) && step && last && !match |=> (state == ST_HUNT) && !in_sync);
  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < len);
endmodule

// File: rtl/slr_status.sv
module slr_status
  import sync_line_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              carrier_s,
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_val,
  input  logic              rd_ack,
  output logic [WORD_W-1:0] rd_data,
  output logic              done,
  output logic              overrun,
  output logic              carrier_lost,
  output logic              irq
);
  logic [DATA_W-1:0] buf_q;
  logic              car_prev, car_fell;

  assign car_fell = car_prev & ~carrier_s;
  assign rd_data  = {{(WORD_W-DATA_W){1'b0}}, buf_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q        <= '0;
      done         <= 1'b0;
      overrun      <= 1'b0;
      carrier_lost <= 1'b0;
      car_prev     <= 1'b0;
      irq          <= 1'b0;
    end else begin
      car_prev <= carrier_s;
      if (char_done) buf_q <= char_val;
      done         <= char_done | (done & ~rd_ack);
      overrun      <= (overrun & ~rd_ack) | (char_done & done & ~rd_ack);
      carrier_lost <= (carrier_lost & ~rd_ack) | (car_fell & en);
      irq          <= done | carrier_lost;
    end
  end

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    char_done && done && !rd_ack |=> overrun && (rd_data[DATA_W-1:0] == $past(char_val)));
  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_ack && !char_done |=> !done);
  // R8
  carrier_flag_chk: assert property (@(posedge clk) disable iff (rst)
    en && $fell(carrier_s) |=> carrier_lost);
  // R9
  enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
    char_done |-> en);
endmodule

// File: rtl/sync_line_rx.sv
module sync_line_rx
  import sync_line_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_clk,
  input  logic              rx_data,
  input  logic              carrier,
  input  logic              rx_en,
  input  logic [1:0]        len_sel,
  input  logic [DATA_W-1:0] sync_pat,
  input  logic              two_sync,
  input  logic              rd_ack,
  output logic [WORD_W-1:0] rd_data,
  output logic              done,
  output logic              overrun,
  output logic              carrier_lost,
  output logic              in_sync,
  output logic              irq
);
  logic              bit_tick, bit_val, carrier_s, char_done;
  logic [DATA_W-1:0] char_val;

  slr_input_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .rx_clk(rx_clk), .rx_data(rx_data), .carrier(carrier),
    .bit_tick(bit_tick), .bit_val(bit_val), .carrier_s(carrier_s)
  );

  slr_framer u_framer (
    .clk(clk), .rst(rst), .en(rx_en), .bit_tick(bit_tick), .bit_val(bit_val),
    .len_sel(len_sel), .sync_pat(sync_pat), .two_sync(two_sync),
    .char_done(char_done), .char_val(char_val), .in_sync(in_sync)
  );

  slr_status u_status (
    .clk(clk), .rst(rst), .en(rx_en), .carrier_s(carrier_s),
    .char_done(char_done), .char_val(char_val), .rd_ack(rd_ack),
    .rd_data(rd_data), .done(done), .overrun(overrun),
    .carrier_lost(carrier_lost), .irq(irq)
  );
endmodule

// File: tb/sync_line_rx_bench.sv
module sync_line_rx_bench;
  logic        clk = 0, rst = 1;
  logic        rx_clk = 0, rx_data = 0, carrier = 1, rx_en = 0;
  logic [1:0]  len_sel = 0;
  logic [11:0] sync_pat = 0;
  logic        two_sync = 0, rd_ack = 0;
  logic [15:0] rd_data;
  logic        done, overrun, carrier_lost, in_sync, irq;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  sync_line_rx u_sync_line_rx (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    rx_data = b;
    wait_clk(4);
    rx_clk = 1;
    wait_clk(4);
    rx_clk = 0;
  endtask

  task automatic send_char(input int v, input int len);
    for (int b = 0; b < len; b++) send_bit(v[b]);
  endtask

  task automatic read_buf();
    rd_ack = 1;
    wait_clk(1);
    rd_ack = 0;
    wait_clk(2);
  endtask

  function automatic int len_of(input logic [1:0] s);
    return (s == 2'b00) ? 6 : (s == 2'b01) ? 8 : 12;
  endfunction

  task automatic start(input logic [1:0] s, input logic [11:0] sp, input logic two);
    rx_en = 0;
    wait_clk(2);
    len_sel = s; sync_pat = sp; two_sync = two;
    rx_en = 1;
    wait_clk(2);
    for (int i = 0; i < 14; i++) send_bit(1'b0);
  endtask

  task automatic run_cfg(input logic [1:0] s, input logic [11:0] sp, input logic two,
                         input int n, input int stp);
    int len = len_of(s);
    int mask = (1 << len) - 1;
    start(s, sp, two);
    send_char(sp, len);
    wait_clk(6);
    // R4: one sync is not enough in two-sync mode
    if (two) check(!in_sync && !done, "R4 in_sync after one sync", in_sync, 0);
    if (two) send_char(sp, len);
    wait_clk(6);
    // R3 R5: sync declared, sync itself not delivered
    check(in_sync && !done, "R3 in_sync after sync", {done, in_sync}, 1);
    for (int i = 0; i < n; i++) begin
      int v = (i * stp) & mask;
      send_char(v, len);
      wait_clk(6);
      // R1 R2 R5 R6
      check(done && rd_data == 16'(v), "R1 R2 character", {15'(0), done, rd_data}, {16'(1), 16'(v)});
      check(irq, "R6 irq with done", irq, 1);
      read_buf();
      check(!done && !overrun, "R6 done cleared by read", {done, overrun}, 0);
    end
  endtask

  initial begin
    wait_clk(3);
    rst = 0;
    wait_clk(2);
    // R10
    check({rd_data, done, overrun, carrier_lost, in_sync, irq} == '0, "R10 reset state",
          {rd_data, done, overrun, carrier_lost, in_sync, irq}, 0);

    // R1 R3 R5: sweeps over lengths and sync modes; high bits of the pattern ignored
    for (int t = 0; t < 2; t++) begin
      run_cfg(2'b00, 12'hF2D, 1'(t), 64, 1);
      run_cfg(2'b01, 12'h397, 1'(t), 256, 1);
      run_cfg(2'b10, 12'hA53, 1'(t), 64, 67);
      run_cfg(2'b11, 12'hA53, 1'(t), 16, 251);
    end

    // R4: second character not a sync sends the receiver back to hunting
    start(2'b01, 12'h097, 1'b1);
    send_char(12'h097, 8);
    send_char(12'h095, 8);
    wait_clk(6);
    check(!in_sync && !done, "R4 missed second sync", {done, in_sync}, 0);
    send_char(12'h000, 8);
    wait_clk(6);
    check(!done, "R4 no framing after miss", done, 0);
    send_char(12'h097, 8);
    send_char(12'h097, 8);
    send_char(12'h0C3, 8);
    wait_clk(6);
    check(in_sync && done && rd_data == 16'h00C3, "R4 recovered", rd_data, 16'h00C3);
    read_buf();

    // R7: overrun keeps the newest character
    start(2'b00, 12'h02D, 1'b0);
    send_char(12'h02D, 6);
    send_char(12'h011, 6);
    send_char(12'h02A, 6);
    wait_clk(6);
    check(done && overrun && rd_data == 16'h002A, "R7 overrun", {overrun, rd_data}, {1'b1, 16'h002A});
    read_buf();
    check(!done && !overrun, "R7 cleared by read", {done, overrun}, 0);

    // R5: a sync-valued character after sync is delivered
    send_char(12'h02D, 6);
    wait_clk(6);
    check(done && rd_data == 16'h002D, "R5 sync value as data", rd_data, 16'h002D);
    read_buf();

    // R8: carrier loss while enabled
    carrier = 0;
    wait_clk(6);
    check(carrier_lost, "R8 carrier lost", carrier_lost, 1);
    wait_clk(1);
    check(irq, "R6 irq with carrier lost", irq, 1);
    read_buf();
    check(!carrier_lost, "R8 cleared by read", carrier_lost, 0);
    carrier = 1;
    wait_clk(6);

    // R9: disable drops sync; re-enable needs a new sync
    rx_en = 0;
    wait_clk(3);
    check(!in_sync, "R9 in_sync low when disabled", in_sync, 0);
    carrier = 0;
    wait_clk(6);
    check(!carrier_lost, "R8 no flag while disabled", carrier_lost, 0);
    carrier = 1;
    send_char(12'h015, 6);
    wait_clk(6);
    check(!done, "R9 nothing received while disabled", done, 0);
    rx_en = 1;
    wait_clk(2);
    send_char(12'h000, 6);
    send_char(12'h015, 6);
    wait_clk(6);
    check(!done && !in_sync, "R9 hunt after re-enable", {done, in_sync}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule